// File: doc/BRIEF.md
# Serial Memory Command Front-End

This block is the target-side engine of a serial peripheral interface in front of a small byte-addressed memory. It runs on the chip clock. It brings the external serial clock, select, data-in and pause inputs into that clock domain, finds the serial clock edges, and decodes each select frame. A frame is an 8-bit command, then a 16-bit address where one is needed, then a stream of data bytes.

Read data is requested from the array one byte ahead through a strobe interface. Write data is handed to the array or to the status path as single-cycle strobes. The write-enable latch lives here. Block protection and page buffering are decided by neighbouring blocks. Those blocks also supply the upper status bits.

Serial data is taken on rising serial clock edges and launched on falling ones. This works whether the serial clock idles low or high. A pause input freezes the frame in place without losing the bit position. The output is released to high impedance whenever the block is deselected or paused.

Top module: `smem_spi_front`

## Requirements
- R1: A frame starts when `cs_n` falls, and the first byte of a frame is the command. When `cs_n` goes high the block returns to idle, so a partly received byte or frame is dropped and the next frame starts again at the command byte.
- R2: Each serial bit, most significant first, is taken from `si` on a rising `sck` edge. `so` changes only after a falling `sck` edge. This works with `sck` idling low (mode 0) and idling high (mode 3).
- R3: Command 0x06 sets `wel` and command 0x04 clears it. When `cs_n` rises at the end of a frame that issued at least one `mem_we` or `sts_we` strobe, `wel` is cleared.
- R4: Command 0x03 is followed by a 16-bit address, most significant byte first. Address bits at and above `AW` are ignored. Data for that address appears on `so` starting with the falling edge after the 24th rising edge.
- R5: During a read, the address advances by one after each byte, wrapping from 2^AW-1 to 0, for as long as `cs_n` stays low.
- R6: Command 0x02 is followed by a 16-bit address. Each complete data byte after it gives one `mem_we` pulse carrying the current address and that byte, then the address advances with wrap. This happens only while `wel` is 1; otherwise the array is left unchanged.
- R7: Command 0x05 returns a status byte on every following byte slot. The byte is `status_in` with bit 1 replaced by `wel`.
- R8: Command 0x01 turns its first data byte into one `sts_we` pulse with `sts_wdata` equal to that byte, only while `wel` is 1. Later bytes in the same frame are ignored.
- R9: Any other command value makes the rest of the frame inert: no `mem_we`, `mem_re` or `sts_we`, `so_oe` stays 0, and `wel` is unchanged.
- R10: `so_oe` is 0 whenever `cs_n` is high or `hold_n` is low.
- R11: While `hold_n` is low, `sck` edges and `si` are ignored. After `hold_n` returns high, the transfer continues from the same bit.
- R12: `mem_re` is a one-cycle pulse, and `mem_rdata` is taken in the cycle after it. `mem_we` and `mem_re` are never high together. A read of N bytes issues N+1 `mem_re` pulses, because of the prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | chip clock |
| rst_n | input | 1 | active-low asynchronous reset |
| sck | input | 1 | serial clock from the controller |
| cs_n | input | 1 | active-low select |
| si | input | 1 | serial data in |
| hold_n | input | 1 | active-low pause |
| so | output | 1 | serial data out value |
| so_oe | output | 1 | output enable for `so` (0 = high impedance) |
| mem_addr | output | AW | array byte address |
| mem_wdata | output | 8 | array write byte |
| mem_we | output | 1 | array write strobe |
| mem_re | output | 1 | array read strobe |
| mem_rdata | input | 8 | array read byte, valid the cycle after `mem_re` |
| status_in | input | 8 | status bits supplied by neighbouring blocks |
| sts_we | output | 1 | status write strobe |
| sts_wdata | output | 8 | status write byte |
| wel | output | 1 | write-enable latch |

## Verification
The assertions assume that the serial inputs change slowly compared with `clk`. Each `sck` phase and each `hold_n` change must last several clock cycles, so every edge passes through the synchronizer as one clean event. The assertions also assume that `hold_n` changes only while `sck` is high, and that `cs_n` changes only between bits. The stimulus keeps to this by holding every serial clock phase for six clock cycles. It also moves `hold_n` and `cs_n` only after a full phase has elapsed with `sck` stable.

// File: rtl/smsf_pkg.sv
`timescale 1ns/1ps
package smsf_pkg;

  typedef enum logic [2:0] {
    PH_OPC   = 3'd0,
    PH_AHI   = 3'd1,
    PH_ALO   = 3'd2,
    PH_RDAT  = 3'd3,
    PH_WDAT  = 3'd4,
    PH_SREAD = 3'd5,
    PH_SWR   = 3'd6,
    PH_IGN   = 3'd7
  } phase_t;

  localparam logic [7:0] CMD_SETWE = 8'h06;
  localparam logic [7:0] CMD_CLRWE = 8'h04;
  localparam logic [7:0] CMD_STRD  = 8'h05;
  localparam logic [7:0] CMD_STWR  = 8'h01;
  localparam logic [7:0] CMD_RD    = 8'h03;
  localparam logic [7:0] CMD_WR    = 8'h02;

  // phase entered after a command byte
  function automatic phase_t cmd_phase(input logic [7:0] op);
    case (op)
      CMD_STRD:      return PH_SREAD;
      CMD_STWR:      return PH_SWR;
      CMD_RD, CMD_WR: return PH_AHI;
      default:       return PH_IGN;
    endcase
  endfunction

  // keep only the low aw bits of a 16-bit address
  function automatic logic [15:0] addr_fold(input logic [15:0] a, input int unsigned aw);
    return a & ((16'h1 << aw) - 16'h1);
  endfunction

  // next address with wrap at the array top
  function automatic logic [15:0] addr_next(input logic [15:0] a, input int unsigned aw);
    return addr_fold(a + 16'h1, aw);
  endfunction

  // status byte as seen by the controller
  function automatic logic [7:0] status_merge(input logic [7:0] st, input logic we_latch);
    return {st[7:2], we_latch, st[0]};
  endfunction

endpackage

// File: rtl/smsf_sync.sv
`timescale 1ns/1ps
module smsf_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/smsf_cmd.sv
`timescale 1ns/1ps
module smsf_cmd
  import smsf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rise_ev,
  input  logic          si_b,
  input  logic [7:0]    status_in,
  input  logic [7:0]    mem_rdata,
  output phase_t        phase,
  output logic [2:0]    bit_cnt,
  output logic          byte_done,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          sts_we,
  output logic [7:0]    sts_wdata,
  output logic          wel,
  output logic [7:0]    tx_byte
);
  logic [6:0]    shreg;
  logic [7:0]    rx_byte;
  logic [7:0]    addr_hi;
  logic          is_rd;
  logic          wr_issued;
  logic          step;
  logic          rd_cap;
  logic [AW-1:0] addr_q;

  assign rx_byte   = {shreg, si_b};
  assign byte_done = rise_ev && (bit_cnt == 3'd7);
  assign mem_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OPC;
      bit_cnt   <= '0;
      shreg     <= '0;
      addr_hi   <= '0;
      is_rd     <= 1'b0;
      wr_issued <= 1'b0;
      step      <= 1'b0;
      rd_cap    <= 1'b0;
      addr_q    <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      sts_we    <= 1'b0;
      sts_wdata <= '0;
      wel       <= 1'b0;
      tx_byte   <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      sts_we <= 1'b0;
      rd_cap <= mem_re;
      if (rd_cap) tx_byte <= mem_rdata;
      if (step) begin
        addr_q <= AW'(addr_next(16'(addr_q), AW));
        step   <= 1'b0;
      end
      if (!sel) begin
        phase   <= PH_OPC;
        bit_cnt <= '0;
        if (wr_issued) begin
          wel       <= 1'b0;
          wr_issued <= 1'b0;
        end
      end else if (rise_ev) begin
        shreg   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_done) begin
          case (phase)
            PH_OPC: begin
              phase <= cmd_phase(rx_byte);
              is_rd <= (rx_byte == CMD_RD);
              if (rx_byte == CMD_SETWE) wel <= 1'b1;
              if (rx_byte == CMD_CLRWE) wel <= 1'b0;
              if (rx_byte == CMD_STRD)  tx_byte <= status_merge(status_in, wel);
            end
            PH_AHI: begin
              addr_hi <= rx_byte;
              phase   <= PH_ALO;
            end
            PH_ALO: begin
              addr_q <= AW'(addr_fold({addr_hi, rx_byte}, AW));
              if (is_rd) begin
                phase  <= PH_RDAT;
                mem_re <= 1'b1;
              end else begin
                phase  <= PH_WDAT;
              end
            end
            PH_RDAT: begin
              addr_q <= AW'(addr_next(16'(addr_q), AW));
              mem_re <= 1'b1;
            end
            PH_WDAT: begin
              mem_we    <= wel;
              mem_wdata <= rx_byte;
              wr_issued <= wr_issued | wel;
              step      <= 1'b1;
            end
            PH_SREAD: tx_byte <= status_merge(status_in, wel);
            PH_SWR: begin
              sts_we    <= wel;
              sts_wdata <= rx_byte;
              wr_issued <= wr_issued | wel;
              phase     <= PH_IGN;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smsf_tx.sv
`timescale 1ns/1ps
module smsf_tx
  import smsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       hold_ok,
  input  logic       fall_ev,
  input  phase_t     phase,
  input  logic [2:0] bit_cnt,
  input  logic [7:0] tx_byte,
  output logic       so,
  output logic       so_oe
);
  logic drive_ph;
  logic so_q;

  assign drive_ph = (phase == PH_RDAT) || (phase == PH_SREAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     so_q <= 1'b0;
    else if (!sel)                  so_q <= 1'b0;
    else if (fall_ev && drive_ph)   so_q <= tx_byte[3'd7 - bit_cnt];
  end

  assign so    = so_q;
  assign so_oe = sel && hold_ok && drive_ph;
endmodule

// File: rtl/smem_spi_front.sv
`timescale 1ns/1ps
module smem_spi_front
  import smsf_pkg::*;
#(
  parameter int AW          = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          hold_n,
  output logic          so,
  output logic          so_oe,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata,
  input  logic [7:0]    status_in,
  output logic          sts_we,
  output logic [7:0]    sts_wdata,
  output logic          wel
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] pins_s;
  logic            cs_n_s, hold_n_s, sck_s, si_s;
  logic            sck_q;
  logic            sel, hold_ok;
  logic            rise_ev, fall_ev;
  logic            byte_done;
  phase_t          phase;
  logic [2:0]      bit_cnt;
  logic [7:0]      tx_byte;

  smsf_sync #(
    .STAGES (SYNC_STAGES),
    .W      (NSIG),
    .RST_VAL(4'b1100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, hold_n, sck, si}),
    .q    (pins_s)
  );

  assign {cs_n_s, hold_n_s, sck_s, si_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign sel     = !cs_n_s;
  assign hold_ok = hold_n_s;
  assign rise_ev = sel && hold_ok && sck_s && !sck_q;
  assign fall_ev = sel && hold_ok && !sck_s && sck_q;

  smsf_cmd #(.AW(AW)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rise_ev  (rise_ev),
    .si_b     (si_s),
    .status_in(status_in),
    .mem_rdata(mem_rdata),
    .phase    (phase),
    .bit_cnt  (bit_cnt),
    .byte_done(byte_done),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .sts_we   (sts_we),
    .sts_wdata(sts_wdata),
    .wel      (wel),
    .tx_byte  (tx_byte)
  );

  smsf_tx u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .hold_ok(hold_ok),
    .fall_ev(fall_ev),
    .phase  (phase),
    .bit_cnt(bit_cnt),
    .tx_byte(tx_byte),
    .so     (so),
    .so_oe  (so_oe)
  );
endmodule

// File: rtl/smsf_checker.sv
`timescale 1ns/1ps
module smsf_checker
  import smsf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       hold_ok,
  input logic       byte_done,
  input logic       so_oe,
  input logic       mem_we,
  input logic       mem_re,
  input logic       sts_we,
  input logic       wel,
  input phase_t     phase,
  input logic [2:0] bit_cnt
);
  AST_IDLE_WHEN_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bit_cnt == 3'd0 && phase == PH_OPC)); // R1

  AST_SO_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !so_oe); // R10

  AST_SO_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ok |-> !so_oe); // R10

  AST_HOLD_KEEPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !hold_ok) |=> $stable(bit_cnt)); // R11

  AST_HOLD_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ok |-> !byte_done); // R11

  AST_WE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel); // R6

  AST_STS_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |-> wel); // R8

  AST_IGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN && $past(phase) == PH_IGN) |-> (!mem_we && !mem_re && !sts_we && !so_oe)); // R9

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R12

  AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re); // R12
endmodule

bind smem_spi_front smsf_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .hold_ok  (hold_ok),
  .byte_done(byte_done),
  .so_oe    (so_oe),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .sts_we   (sts_we),
  .wel      (wel),
  .phase    (phase),
  .bit_cnt  (bit_cnt)
);

// File: tb/tb_smem_spi_front.sv
`timescale 1ns/1ps
module tb_smem_spi_front;
  localparam int AW   = 10;
  localparam int SIZE = 1 << AW;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, status_in, sts_wdata;
  logic mem_we, mem_re, sts_we, wel;

  always #2.5 clk = ~clk;

  smem_spi_front #(.AW(AW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .status_in(status_in), .sts_we(sts_we), .sts_wdata(sts_wdata), .wel(wel)
  );

  // array model and strobe monitors
  logic [7:0] bmem [SIZE];
  logic [7:0] smem [SIZE];
  int we_cnt = 0, re_cnt = 0, sts_cnt = 0;
  logic [7:0] sts_last = 8'h00;
  logic oe_seen = 1'b0;
  logic oe_clear = 1'b0;

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (mem_re) begin
      mem_rdata <= bmem[mem_addr];
      re_cnt <= re_cnt + 1;
    end
    if (sts_we) begin
      sts_cnt <= sts_cnt + 1;
      sts_last <= sts_wdata;
    end
    if (oe_clear) oe_seen <= 1'b0;
    else if (so_oe) oe_seen <= 1'b1;
  end

  int checks = 0, errors = 0;
  bit mode3 = 1'b0;
  bit exp_wel = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  function automatic logic [AW-1:0] fold(input logic [15:0] a);
    return a[AW-1:0];
  endfunction

  function automatic logic [7:0] exp_status(input logic [7:0] st, input bit w);
    logic [7:0] r;
    r = st;
    r[1] = w;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic do_hold();
    hold_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(so_oe == 1'b0, "R10", "so_oe during hold", 32'(so_oe), 0);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b0; si = ~si; half_wait();
      sck = 1'b1; half_wait();
    end
    hold_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int hold_at, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = tx[i];
      half_wait();
      rx[i] = so_oe ? so : 1'b0;
      sck = 1'b1;
      half_wait();
      if (hold_at == i) do_hold();
    end
  endtask

  task automatic begin_frame();
    sck = mode3;
    half_wait();
    cs_n = 1'b0;
    half_wait();
  endtask

  task automatic end_frame();
    half_wait();
    if (!mode3) sck = 1'b0;
    half_wait();
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    begin_frame();
    xfer(op, -1, r);
    end_frame();
    if (op == 8'h06) exp_wel = 1'b1;
    if (op == 8'h04) exp_wel = 1'b0;
  endtask

  task automatic wr_frame(input logic [15:0] a, input int n, input int hold_at);
    logic [7:0] r;
    begin_frame();
    xfer(8'h02, -1, r);
    xfer(a[15:8], -1, r);
    xfer(a[7:0], -1, r);
    for (int i = 0; i < n; i++) xfer(wbuf[i], (i == 0) ? hold_at : -1, r);
    end_frame();
    if (exp_wel && n > 0) begin
      for (int i = 0; i < n; i++) smem[fold(a + 16'(i))] = wbuf[i];
      exp_wel = 1'b0;
    end
  endtask

  task automatic rd_frame(input logic [15:0] a, input int n, input int hold_at);
    logic [7:0] r;
    begin_frame();
    xfer(8'h03, -1, r);
    xfer(a[15:8], -1, r);
    xfer(a[7:0], -1, r);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, (i == 0) ? hold_at : -1, r);
      rbuf[i] = r;
    end
    end_frame();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int we0, re0, st0, n;
    logic [15:0] a, a2;
    logic [7:0] r, st;
    void'($urandom(32'd1234));
    status_in = 8'hA5;
    mem_rdata = 8'h00;
    for (int i = 0; i < SIZE; i++) begin
      bmem[i] = 8'((i * 7) ^ 8'h3C);
      smem[i] = 8'((i * 7) ^ 8'h3C);
    end
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk(so_oe == 1'b0, "R10", "so_oe after reset", 32'(so_oe), 0);
    chk(wel == 1'b0, "R3", "wel after reset", 32'(wel), 0);
    chk(!mem_we && !mem_re, "R12", "strobes after reset", {mem_we, mem_re}, 0);

    // write-enable latch commands
    cmd1(8'h06);
    chk(wel == 1'b1, "R3", "wel after 0x06", 32'(wel), 1);
    cmd1(8'h04);
    chk(wel == 1'b0, "R3", "wel after 0x04", 32'(wel), 0);

    // write with latch clear: no effect
    we0 = we_cnt;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_frame(16'h0010, 2, -1);
    chk(we_cnt == we0, "R6", "write strobes without wel", we_cnt - we0, 0);
    rd_frame(16'h0010, 2, -1);
    for (int i = 0; i < 2; i++)
      chk(rbuf[i] == smem[16 + i], "R6", "array after blocked write", rbuf[i], smem[16 + i]);

    // write with upper address bits set, then read them back
    cmd1(8'h06);
    we0 = we_cnt;
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    wr_frame(16'hFC05, 3, -1);
    chk(we_cnt - we0 == 3, "R6", "write strobe count", we_cnt - we0, 3);
    chk(wel == 1'b0, "R3", "wel after write frame", 32'(wel), 0);
    re0 = re_cnt;
    rd_frame(16'h0005, 3, -1);
    chk(re_cnt - re0 == 4, "R12", "read strobes for 3 bytes", re_cnt - re0, 4);
    for (int i = 0; i < 3; i++)
      chk(rbuf[i] == smem[5 + i], "R4", "read after folded write", rbuf[i], smem[5 + i]);
    chk(so_oe == 1'b0, "R10", "so_oe after frame end", 32'(so_oe), 0);

    // wrap at the top, mode 3
    mode3 = 1'b1;
    rd_frame(16'h03FE, 4, -1);
    chk(rbuf[0] == smem[SIZE-2], "R5", "byte at top-1", rbuf[0], smem[SIZE-2]);
    chk(rbuf[1] == smem[SIZE-1], "R5", "byte at top", rbuf[1], smem[SIZE-1]);
    chk(rbuf[2] == smem[0], "R5", "wrapped byte 0", rbuf[2], smem[0]);
    chk(rbuf[3] == smem[1], "R5", "wrapped byte 1", rbuf[3], smem[1]);
    mode3 = 1'b0;

    // status read
    st = 8'($urandom);
    status_in = st;
    cmd1(8'h06);
    begin_frame();
    xfer(8'h05, -1, r);
    xfer(8'h00, -1, r);
    chk(r == exp_status(st, 1'b1), "R7", "status byte 1", r, exp_status(st, 1'b1));
    xfer(8'h00, -1, r);
    chk(r == exp_status(st, 1'b1), "R7", "status byte 2", r, exp_status(st, 1'b1));
    end_frame();

    // status write
    cmd1(8'h04);
    st0 = sts_cnt;
    begin_frame(); xfer(8'h01, -1, r); xfer(8'h8C, -1, r); end_frame();
    chk(sts_cnt == st0, "R8", "status write without wel", sts_cnt - st0, 0);
    cmd1(8'h06);
    begin_frame(); xfer(8'h01, -1, r); xfer(8'h9C, -1, r); xfer(8'h55, -1, r); end_frame();
    exp_wel = 1'b0;
    chk(sts_cnt - st0 == 1, "R8", "status write strobes", sts_cnt - st0, 1);
    chk(sts_last == 8'h9C, "R8", "status write byte", sts_last, 8'h9C);
    chk(wel == 1'b0, "R3", "wel after status write", 32'(wel), 0);

    // unknown command
    cmd1(8'h06);
    we0 = we_cnt; re0 = re_cnt; st0 = sts_cnt;
    @(negedge clk); oe_clear = 1'b1; @(negedge clk); oe_clear = 1'b0;
    begin_frame();
    xfer(8'hA7, -1, r); xfer(8'h03, -1, r); xfer(8'h02, -1, r);
    xfer(8'h00, -1, r); xfer(8'h01, -1, r); xfer(8'h04, -1, r);
    end_frame();
    chk(we_cnt == we0 && re_cnt == re0 && sts_cnt == st0, "R9", "strobes after unknown cmd",
        (we_cnt - we0) + (re_cnt - re0) + (sts_cnt - st0), 0);
    chk(oe_seen == 1'b0, "R9", "so_oe in unknown frame", 32'(oe_seen), 0);
    chk(wel == 1'b1, "R9", "wel kept after unknown cmd", 32'(wel), 1);

    // pause in the middle of a write and a read, mode 3
    mode3 = 1'b1;
    wbuf[0] = 8'h6B; wbuf[1] = 8'hD4;
    wr_frame(16'h0123, 2, 4);
    rd_frame(16'h0123, 2, 3);
    chk(rbuf[0] == smem[16'h123], "R11", "paused byte 0", rbuf[0], smem[16'h123]);
    chk(rbuf[1] == smem[16'h124], "R11", "paused byte 1", rbuf[1], smem[16'h124]);
    mode3 = 1'b0;

    // aborted partial frame then restart at the command byte
    begin_frame();
    xfer(8'h03, -1, r);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; si = 1'b1; half_wait(); sck = 1'b1; half_wait();
    end
    end_frame();
    cmd1(8'h06);
    chk(wel == 1'b1, "R1", "command after aborted frame", 32'(wel), 1);
    cmd1(8'h04);

    // random traffic over both serial modes
    for (int it = 0; it < 30; it++) begin
      mode3 = 1'($urandom);
      if (($urandom % 4) != 0) cmd1(8'h06);
      a = 16'($urandom);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_frame(a, n, -1);
      a2 = {6'($urandom), a[9:0]};
      rd_frame(a2, n, -1);
      for (int i = 0; i < n; i++)
        chk(rbuf[i] == smem[fold(a + 16'(i))], "R2 R6", "random readback",
            rbuf[i], smem[fold(a + 16'(i))]);
    end

    finish_run();
  end
endmodule